// File: doc/BRIEF.md
# Vectored Interrupt Controller for a Small Processor Core

This block gathers request events from ten on-chip sources into per-source flag bits. It combines the flags with per-source enables, a peripheral group enable and a global enable, and gives a simple processor front end one interrupt decision per instruction cycle. When it accepts a request, the block clears the global enable, saves the core's return address on a small hardware return stack and tells the core to load the fixed vector address. A return indication from the core pops the saved address and sets the global enable again.

Three of the sources (the external edge pin, timer 0 overflow and the port-change detector) keep their flags and enables in the main control register, next to the two enable bits. The other seven sources keep theirs in a peripheral flag register and a peripheral enable register. A wake output reports any flag whose enables are set, even while the global enable is clear, so sleep logic can restart the clock. When the core executes an instruction that clears the global enable, the block suppresses the next instruction cycle with a forced no-op. Requests that were pending at that time stay pending.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the control, peripheral flag and peripheral enable registers all read 0, and `wake_o`, `irq_req_o`, `take_o`, `pc_load_o` and `force_nop_o` are low.
- R2: Event bit k of `evt_i` sets its flag on the next clock edge, whatever the state of its own enable, the group enable or the global enable. Bits 0, 1 and 2 are the pin, timer 0 and port-change sources. Bits 3 to 9 are timer 1, timer 2, capture/compare, comparator, serial transmit, serial receive and EEPROM done.
- R3: The register select codes are 0 for control, 1 for peripheral flags and 2 for peripheral enables. In the control register, bit 7 is the global enable, bit 6 is the peripheral group enable, bits 5:3 are the enables and bits 2:0 are the flags of sources 0 to 2. In the peripheral registers, bit j belongs to source j+3, and bit 7 always reads 0.
- R4: `wake_o` is high while any main flag has its enable set, or while any peripheral flag has its enable set and the group enable is set. The global enable does not affect it.
- R5: `irq_req_o` equals `wake_o` while the global enable is set, and is low otherwise.
- R6: Acceptance is sampled at instruction strobes. If a request is present before strobe N, the strobe samples it. At strobe N+1, `take_o` and `pc_load_o` pulse with `pc_target_o` = 0x0004, `pc_i` is pushed onto the return stack, and the global enable clears.
- R7: A return (`ret_i` together with the strobe) drives `pc_load_o` with `pc_target_o` equal to the most recently pushed address, pops it, and sets the global enable. Nested returns come back in last-in, first-out order.
- R8: A global-disable instruction (`gdis_i` together with the strobe) clears the global enable. `force_nop_o` is then high through the next instruction cycle, up to and including the next strobe, and no acceptance happens at that strobe. The flag stays set and fires again once the global enable is set.
- R9: Hardware never clears a flag. Acceptance leaves the flag set, so an uncleared source is accepted again after a return.
- R10: A register write that clears a flag in the same clock as a new event for that source leaves that flag set. The other written bits take the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 10 | One-clock event pulses, one per source |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select (0 control, 1 peripheral flags, 2 peripheral enables) |
| wr_data_i | input | 8 | Register write data |
| cyc_stb_i | input | 1 | One-clock pulse at the end of each instruction cycle |
| ret_i | input | 1 | Return-from-interrupt executed (valid with strobe) |
| gdis_i | input | 1 | Global-enable-clearing instruction executed (valid with strobe) |
| pc_i | input | 13 | Return address offered by the core |
| ctrl_q_o | output | 8 | Control register readback |
| pflag_q_o | output | 8 | Peripheral flag register readback |
| pen_q_o | output | 8 | Peripheral enable register readback |
| wake_o | output | 1 | Enabled flag present, global enable ignored |
| irq_req_o | output | 1 | Combined request qualified by global enable |
| take_o | output | 1 | Interrupt accepted at this strobe |
| pc_load_o | output | 1 | Core must load `pc_target_o` |
| pc_target_o | output | 13 | Vector address or popped return address |
| force_nop_o | output | 1 | Current instruction cycle is suppressed |

## Verification
The assertions assume that the core raises `ret_i` and `gdis_i` only in the clock where `cyc_stb_i` is high, and never raises both together. They also assume that software clears the global enable only through `gdis_i`, or while it is already clear inside a handler. The stack checks assume a return never arrives in the same strobe as an acceptance, and that nesting does not exceed the stack depth. The bench drives every control input from one task that sets all of them in a single clock. Returns and global-disable pulses are issued only together with a strobe, and the global enable is written only while no sampled request can slip through.

// File: rtl/irq_pkg.sv
// Shared constants and types for the interrupt controller.
// Assumes an 8-bit register file and ten sources: three main, seven peripheral.
package irq_pkg;
    localparam int REG_W   = 8;
    localparam int N_MAIN  = 3;
    localparam int N_PERI  = 7;
    localparam int N_SRC   = N_MAIN + N_PERI;
    localparam int GIE_BIT = 7;
    localparam int GRP_BIT = 6;
    localparam int EN_LSB  = N_MAIN;

    // Source indices on the event vector
    localparam int SRC_PIN   = 0;
    localparam int SRC_TMR0  = 1;
    localparam int SRC_PCHG  = 2;
    localparam int SRC_TMR1  = 3;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_PFLAG = 2'd1,
        SEL_PEN   = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/irq_flag_bank.sv
// Flag and enable storage. The main flags and enables plus the group enable
// sit in the low seven bits of the control register. The peripheral flags and
// enables sit in their own registers. An event ORs into its flag after any
// same-cycle write, so a write cannot lose a new event.
// Assumes evt_i bits are single-clock pulses. The global enable bit lives in the sequencer.
module irq_flag_bank
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  evt_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [REG_W-2:0]  wr_data_i,
    output logic [N_MAIN-1:0] mflag_o,
    output logic [N_MAIN-1:0] men_o,
    output logic              grp_en_o,
    output logic [N_PERI-1:0] pflag_o,
    output logic [N_PERI-1:0] pen_o
);
    logic [N_MAIN-1:0] mflag_q, men_q, mflag_d, men_d;
    logic              grp_q, grp_d;
    logic [N_PERI-1:0] pflag_q, pen_q, pflag_d, pen_d;
    logic              wr_ctrl, wr_pflag, wr_pen;

    assign wr_ctrl  = wr_en_i && (wr_sel_i == SEL_CTRL);
    assign wr_pflag = wr_en_i && (wr_sel_i == SEL_PFLAG);
    assign wr_pen   = wr_en_i && (wr_sel_i == SEL_PEN);

    // Next-state: write value first, then new events ORed on top
    always_comb begin
        mflag_d = wr_ctrl ? wr_data_i[N_MAIN-1:0] : mflag_q;
        mflag_d = mflag_d | evt_i[N_MAIN-1:0];
        men_d   = wr_ctrl ? wr_data_i[EN_LSB +: N_MAIN] : men_q;
        grp_d   = wr_ctrl ? wr_data_i[GRP_BIT] : grp_q;
        pflag_d = wr_pflag ? wr_data_i[N_PERI-1:0] : pflag_q;
        pflag_d = pflag_d | evt_i[N_SRC-1:N_MAIN];
        pen_d   = wr_pen ? wr_data_i[N_PERI-1:0] : pen_q;
    end

    // Register update with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mflag_q <= '0;
            men_q   <= '0;
            grp_q   <= 1'b0;
            pflag_q <= '0;
            pen_q   <= '0;
        end else begin
            mflag_q <= mflag_d;
            men_q   <= men_d;
            grp_q   <= grp_d;
            pflag_q <= pflag_d;
            pen_q   <= pen_d;
        end
    end

    assign mflag_o  = mflag_q;
    assign men_o    = men_q;
    assign grp_en_o = grp_q;
    assign pflag_o  = pflag_q;
    assign pen_o    = pen_q;

    // R2
    evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((({pflag_q, mflag_q}) & $past(evt_i)) == $past(evt_i)));

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && evt_i == '0) |=> ($stable(mflag_q) && $stable(pflag_q)));
endmodule

// File: rtl/irq_combiner.sv
// Combines the flags with their enables. The wake output ignores the global
// enable. The request output is the wake condition qualified by it.
// Assumes all inputs come from registers, so both outputs are glitch-free per cycle.
module irq_combiner
    import irq_pkg::*;
(
    input  logic [N_MAIN-1:0] mflag_i,
    input  logic [N_MAIN-1:0] men_i,
    input  logic              grp_en_i,
    input  logic [N_PERI-1:0] pflag_i,
    input  logic [N_PERI-1:0] pen_i,
    input  logic              gie_i,
    output logic              wake_o,
    output logic              req_o
);
    logic [N_MAIN-1:0] main_hit;
    logic [N_PERI-1:0] peri_hit;

    // Per-source qualification, one gate per source
    for (genvar m = 0; m < N_MAIN; m++) begin : g_main
        assign main_hit[m] = mflag_i[m] & men_i[m];
    end
    for (genvar p = 0; p < N_PERI; p++) begin : g_peri
        assign peri_hit[p] = pflag_i[p] & pen_i[p];
    end

    // Reduction to wake and request
    always_comb begin
        wake_o = (|main_hit) | (grp_en_i & (|peri_hit));
        req_o  = wake_o & gie_i;
    end
endmodule

// File: rtl/irq_sequencer.sv
// Per-instruction-cycle acceptance. At each strobe the sequencer samples the
// qualified request, then accepts it at the following strobe unless that cycle
// is a forced no-op. It owns the global enable.
// Assumes ret_i and gdis_i arrive only together with stb_i and never together.
module irq_sequencer (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_i,
    input  logic ret_i,
    input  logic gdis_i,
    input  logic gie_wr_i,
    input  logic gie_wr_d_i,
    input  logic req_i,
    output logic gie_o,
    output logic take_o,
    output logic nop_o
);
    logic gie_q, smp_q, blk_q;

    // Acceptance decision in the strobe cycle
    assign take_o = stb_i & smp_q & ~blk_q;

    // Global enable, sampled request and no-op window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_q <= 1'b0;
            smp_q <= 1'b0;
            blk_q <= 1'b0;
        end else begin
            if (take_o || (stb_i && gdis_i))
                gie_q <= 1'b0;
            else if (stb_i && ret_i)
                gie_q <= 1'b1;
            else if (gie_wr_i)
                gie_q <= gie_wr_d_i;
            if (stb_i) begin
                blk_q <= gdis_i;
                smp_q <= take_o ? 1'b0 : req_i;
            end
        end
    end

    assign gie_o = gie_q;
    assign nop_o = blk_q;

    // R6
    take_clr_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !gie_o);

    // R7
    ret_set_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && ret_i && !take_o && !gdis_i) |=> gie_o);

    // R8
    gdis_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && gdis_i) |=> (nop_o && !gie_o));
endmodule

// File: rtl/irq_ret_stack.sv
// Circular return-address stack. A push stores the address at the pointer.
// A pop steps the pointer back. The top entry is always presented.
// Assumes DEPTH is a power of two. Overflow wraps and overwrites the oldest entry.
module irq_ret_stack #(
    parameter int PC_W  = 13,
    parameter int DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_i,
    input  logic            pop_i,
    input  logic [PC_W-1:0] pc_i,
    output logic [PC_W-1:0] top_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PC_W-1:0]  mem_q [DEPTH];
    logic [PTR_W-1:0] ptr_q, top_idx;

    assign top_idx = ptr_q - 1'b1;
    assign top_o   = mem_q[top_idx];

    // Pointer and storage update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (push_i) begin
            mem_q[ptr_q] <= pc_i;
            ptr_q        <= ptr_q + 1'b1;
        end else if (pop_i) begin
            ptr_q <= ptr_q - 1'b1;
        end
    end

    // R6
    push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i) |=> (top_o == $past(pc_i)));
endmodule

// File: rtl/irq_vector_ctrl.sv
// Top of the interrupt controller. It ties the flag bank, the combiner, the
// acceptance sequencer and the return stack together, and drives the core's
// program-counter load with either the fixed vector or a popped return address.
// Assumes the core follows the strobe contract in irq_sequencer.
module irq_vector_ctrl
    import irq_pkg::*;
#(
    parameter int              PC_W      = 13,
    parameter int              STK_DEPTH = 8,
    parameter logic [PC_W-1:0] VEC_ADDR  = 13'h0004
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             cyc_stb_i,
    input  logic             ret_i,
    input  logic             gdis_i,
    input  logic [PC_W-1:0]  pc_i,
    output logic [REG_W-1:0] ctrl_q_o,
    output logic [REG_W-1:0] pflag_q_o,
    output logic [REG_W-1:0] pen_q_o,
    output logic             wake_o,
    output logic             irq_req_o,
    output logic             take_o,
    output logic             pc_load_o,
    output logic [PC_W-1:0]  pc_target_o,
    output logic             force_nop_o
);
    localparam int PAD_W = REG_W - N_PERI;

    logic [N_MAIN-1:0] mflag, men;
    logic [N_PERI-1:0] pflag, pen;
    logic              grp_en, gie, take, do_ret, gie_wr;
    logic [PC_W-1:0]   stk_top;

    assign gie_wr = wr_en_i && (wr_sel_i == SEL_CTRL);
    assign do_ret = cyc_stb_i & ret_i & ~take;

    irq_flag_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i[REG_W-2:0]),
        .mflag_o   (mflag),
        .men_o     (men),
        .grp_en_o  (grp_en),
        .pflag_o   (pflag),
        .pen_o     (pen)
    );

    irq_combiner u_comb (
        .mflag_i  (mflag),
        .men_i    (men),
        .grp_en_i (grp_en),
        .pflag_i  (pflag),
        .pen_i    (pen),
        .gie_i    (gie),
        .wake_o   (wake_o),
        .req_o    (irq_req_o)
    );

    irq_sequencer u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb_i      (cyc_stb_i),
        .ret_i      (ret_i),
        .gdis_i     (gdis_i),
        .gie_wr_i   (gie_wr),
        .gie_wr_d_i (wr_data_i[GIE_BIT]),
        .req_i      (irq_req_o),
        .gie_o      (gie),
        .take_o     (take),
        .nop_o      (force_nop_o)
    );

    irq_ret_stack #(.PC_W(PC_W), .DEPTH(STK_DEPTH)) u_stack (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (take),
        .pop_i  (do_ret),
        .pc_i   (pc_i),
        .top_o  (stk_top)
    );

    // Program-counter load selection and register readback
    always_comb begin
        take_o      = take;
        pc_load_o   = take | do_ret;
        pc_target_o = take ? VEC_ADDR : stk_top;
        ctrl_q_o    = {gie, grp_en, men, mflag};
        pflag_q_o   = {{PAD_W{1'b0}}, pflag};
        pen_q_o     = {{PAD_W{1'b0}}, pen};
    end

    // R9
    take_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr_en_i) |=> ((ctrl_q_o[N_MAIN-1:0] & $past(ctrl_q_o[N_MAIN-1:0]))
                                 == $past(ctrl_q_o[N_MAIN-1:0])));
endmodule

// File: tb/test_irq_vector_ctrl.sv
// Directed bench: one task per scenario, each checking its own results.
module test_irq_vector_ctrl;
    import irq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [9:0]  evt_i;
    logic        wr_en_i;
    logic [1:0]  wr_sel_i;
    logic [7:0]  wr_data_i;
    logic        cyc_stb_i, ret_i, gdis_i;
    logic [12:0] pc_i;
    logic [7:0]  ctrl_q_o, pflag_q_o, pen_q_o;
    logic        wake_o, irq_req_o, take_o, pc_load_o, force_nop_o;
    logic [12:0] pc_target_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    irq_vector_ctrl i_irq_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en_i(wr_en_i),
        .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .cyc_stb_i(cyc_stb_i),
        .ret_i(ret_i), .gdis_i(gdis_i), .pc_i(pc_i), .ctrl_q_o(ctrl_q_o),
        .pflag_q_o(pflag_q_o), .pen_q_o(pen_q_o), .wake_o(wake_o),
        .irq_req_o(irq_req_o), .take_o(take_o), .pc_load_o(pc_load_o),
        .pc_target_o(pc_target_o), .force_nop_o(force_nop_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive every input for one clock, then settle before the next edge
    task automatic step(input logic stb, input logic [9:0] ev, input logic w,
                        input logic [1:0] sel, input logic [7:0] d,
                        input logic r, input logic g);
        @(negedge clk);
        cyc_stb_i = stb; evt_i = ev; wr_en_i = w; wr_sel_i = sel;
        wr_data_i = d; ret_i = r; gdis_i = g;
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, SEL_NONE, '0, 1'b0, 1'b0);
    endtask
    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        step(1'b0, '0, 1'b1, sel, d, 1'b0, 1'b0);
    endtask
    task automatic ev(input logic [9:0] e);
        step(1'b0, e, 1'b0, SEL_NONE, '0, 1'b0, 1'b0);
    endtask
    task automatic strobe();
        step(1'b1, '0, 1'b0, SEL_NONE, '0, 1'b0, 1'b0);
    endtask
    task automatic ret_stb();
        step(1'b1, '0, 1'b0, SEL_NONE, '0, 1'b1, 1'b0);
    endtask
    task automatic gdis_stb();
        step(1'b1, '0, 1'b0, SEL_NONE, '0, 1'b0, 1'b1);
    endtask

    task automatic t_reset();
        idle(1);
        chk("R1 ctrl", ctrl_q_o, 8'h00);
        chk("R1 pflag", pflag_q_o, 8'h00);
        chk("R1 pen", pen_q_o, 8'h00);
        chk("R1 outs", {wake_o, irq_req_o, take_o, pc_load_o, force_nop_o}, 5'b0);
    endtask

    task automatic t_latch_masked();
        ev(10'h3FF); idle(1);
        chk("R2 main flags", ctrl_q_o, 8'h07);
        chk("R2 peri flags", pflag_q_o, 8'h7F);
        chk("R2 no wake", wake_o, 1'b0);
        wr(SEL_PEN, 8'hFF); idle(1);
        chk("R3 pen bit7", pen_q_o, 8'h7F);
        wr(SEL_CTRL, 8'h00); wr(SEL_PFLAG, 8'h00); wr(SEL_PEN, 8'h00); idle(1);
        chk("R3 cleared", {ctrl_q_o, pflag_q_o}, 16'h0000);
    endtask

    task automatic t_wake_gating();
        wr(SEL_CTRL, 8'h08); ev(10'h001); idle(1);
        chk("R4 pin wake", wake_o, 1'b1);
        chk("R5 no gie", irq_req_o, 1'b0);
        wr(SEL_CTRL, 8'h00); wr(SEL_PEN, 8'h01); ev(10'h008); idle(1);
        chk("R4 group off", wake_o, 1'b0);
        wr(SEL_CTRL, 8'h40); idle(1);
        chk("R4 group on", wake_o, 1'b1);
        wr(SEL_CTRL, 8'hC0); idle(1);
        chk("R5 req", irq_req_o, 1'b1);
        wr(SEL_CTRL, 8'h00); wr(SEL_PFLAG, 8'h00); wr(SEL_PEN, 8'h00); idle(1);
        chk("R5 req off", irq_req_o, 1'b0);
    endtask

    task automatic t_accept();
        pc_i = 13'h0123;
        wr(SEL_CTRL, 8'h88); ev(10'h001); idle(1);
        chk("R5 req up", irq_req_o, 1'b1);
        strobe();
        chk("R6 no take first strobe", take_o, 1'b0);
        idle(3); strobe();
        chk("R6 take", {take_o, pc_load_o}, 2'b11);
        chk("R6 vector", pc_target_o, 13'h0004);
        idle(1);
        chk("R9 flag kept gie off", ctrl_q_o, 8'h09);
    endtask

    task automatic t_return_nest();
        ret_stb();
        chk("R7 ret load", pc_load_o, 1'b1);
        chk("R7 ret addr", pc_target_o, 13'h0123);
        idle(1);
        chk("R7 gie set", ctrl_q_o, 8'h89);
        pc_i = 13'h0055;
        strobe(); idle(1); strobe();
        chk("R9 refire", take_o, 1'b1);
        idle(1);
        wr(SEL_CTRL, 8'h89);
        pc_i = 13'h00AA;
        strobe(); idle(1); strobe();
        chk("R7 nested take", take_o, 1'b1);
        wr(SEL_CTRL, 8'h08);
        ret_stb();
        chk("R7 lifo inner", pc_target_o, 13'h00AA);
        ret_stb();
        chk("R7 lifo outer", pc_target_o, 13'h0055);
        wr(SEL_CTRL, 8'h00); idle(1);
    endtask

    task automatic t_gdis();
        pc_i = 13'h0300;
        strobe(); strobe();
        wr(SEL_CTRL, 8'h09); wr(SEL_CTRL, 8'h89);
        gdis_stb();
        chk("R8 no take at gdis", take_o, 1'b0);
        idle(1);
        chk("R8 nop", force_nop_o, 1'b1);
        chk("R8 gie cleared", ctrl_q_o, 8'h09);
        strobe();
        chk("R8 suppressed", {take_o, force_nop_o}, 2'b01);
        idle(1);
        chk("R8 nop ends", force_nop_o, 1'b0);
        chk("R8 pending", ctrl_q_o, 8'h09);
        wr(SEL_CTRL, 8'h89);
        strobe(); strobe();
        chk("R8 later take", take_o, 1'b1);
        wr(SEL_CTRL, 8'h00); ret_stb(); wr(SEL_CTRL, 8'h00); idle(1);
    endtask

    task automatic t_collision();
        wr(SEL_PFLAG, 8'h7F);
        step(1'b0, 10'h010, 1'b1, SEL_PFLAG, 8'h00, 1'b0, 1'b0);
        idle(1);
        chk("R10 peri collide", pflag_q_o, 8'h02);
        wr(SEL_CTRL, 8'h07);
        step(1'b0, 10'h002, 1'b1, SEL_CTRL, 8'h00, 1'b0, 1'b0);
        idle(1);
        chk("R10 main collide", ctrl_q_o, 8'h02);
    endtask

    initial begin
        rst_n = 1'b0; pc_i = '0;
        cyc_stb_i = 0; evt_i = '0; wr_en_i = 0; wr_sel_i = SEL_NONE;
        wr_data_i = '0; ret_i = 0; gdis_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_latch_masked();
        t_wake_gating();
        t_accept();
        t_return_nest();
        t_gdis();
        t_collision();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule